// File: doc/BRIEF.md
# Write Barrier Store-Queue Handler

This block controls a write memory barrier that sits in a store-queue slot. The queue reports three things about the barrier: whether it is present, whether it has retired, and whether every older store has become writable. Once all three hold, the handler freezes the queue's writable pointer at the barrier. It also tells the cache controller to close the I/O write-buffer merge register, so that no later write can merge into an earlier buffer entry. Stores younger than the barrier may still enter the queue, but the frozen pointer stops them from becoming writable.

A configuration bit, latched when the barrier is accepted, selects how completion is reached. With the bit clear, the handler stalls miss-address and write-buffer processing. It marks the youngest probe-queue entry when the 4-bit count of outstanding committed events steps from one to zero. With the bit set, it issues a barrier command toward the system port and marks the probe entry when that command is acknowledged. In both modes, the barrier completes once a probe response has been sent for the marked entry. At that point every stall is lifted in the same cycle, and the barrier slot is released from the queue. Only one barrier is handled at a time; a second one waits behind the frozen pointer.

Top module: `wbar_sq_handler`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, wptr_stall, merge_close, proc_stall, bar_cmd, probe_mark and bar_retire are all 0.
- R2: A barrier is accepted only at a clock edge where bar_valid, bar_retired and older_writable are all 1. If any one of them is 0, the block stays idle and wptr_stall remains 0.
- R3: In the cycle after acceptance, wptr_stall and merge_close go to 1. Both stay at 1 until the release cycle.
- R4: cfg_sys_barrier is sampled at acceptance. When it was 0, proc_stall is 1 for as long as wptr_stall is 1. When it was 1, proc_stall stays 0.
- R5: In clear mode, probe_mark is a one-cycle pulse in the cycle after a clock edge at which the previous evt_cnt value was 1 and the current value is 0. Other counter changes (2 to 1, 3 to 0, staying at 0) give no mark, and cmd_ack has no effect.
- R6: In set mode, bar_cmd is a one-cycle pulse in the cycle after acceptance. probe_mark pulses for one cycle after a clock edge at which cmd_ack is 1, counting from the bar_cmd cycle onward. Changes of evt_cnt have no effect.
- R7: An edge at which probe_rsp_sent is 1 ends the barrier, but only once the probe_mark cycle has passed. In the following cycle, bar_retire is 1 for one cycle and wptr_stall, merge_close and proc_stall are all 0. A probe_rsp_sent before the mark is ignored.
- R8: A change of cfg_sys_barrier while a barrier is active has no effect on that barrier.
- R9: While a barrier is active or being released, a new acceptance condition is ignored. In the cycle after bar_retire, the next barrier can be accepted, and its stalls appear one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sys_barrier | input | 1 | 1: complete through a system command and its acknowledge; 0: complete through the event counter |
| bar_valid | input | 1 | A write barrier is the oldest not-yet-writable store-queue slot |
| bar_retired | input | 1 | That barrier has retired |
| older_writable | input | 1 | Every store older than the barrier is writable |
| evt_cnt | input | CNT_W | Count of outstanding committed events |
| cmd_ack | input | 1 | The system acknowledged the barrier command |
| probe_rsp_sent | input | 1 | A probe response was sent for the marked entry |
| wptr_stall | output | 1 | Freeze the store-queue writable pointer |
| merge_close | output | 1 | Close the I/O write-buffer merge register |
| proc_stall | output | 1 | Hold miss-address and write-buffer processing (clear mode) |
| bar_cmd | output | 1 | One-cycle barrier command toward the system port (set mode) |
| probe_mark | output | 1 | One-cycle mark of the youngest probe-queue entry |
| bar_retire | output | 1 | One-cycle release of the barrier slot |

## Verification
The assertions check properties that hold on every cycle. A stall can only rise after all three acceptance inputs were seen together. The processing stall never appears without the pointer stall. Marks and commands last one cycle each, and a mark occurs only while the pointer is frozen. Release follows a probe response and drops every stall at once. Only the bench's scenarios can show that the right counter transition or acknowledge produces the mark and that look-alike transitions do not. They are also needed to show that the mode stays latched across a mid-barrier change, that an early probe response is ignored, and how a second barrier is spaced from the first.

// File: rtl/wbar_sq_handler.sv
module wbar_sq_handler #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_sys_barrier,
  input  logic             bar_valid,
  input  logic             bar_retired,
  input  logic             older_writable,
  input  logic [CNT_W-1:0] evt_cnt,
  input  logic             cmd_ack,
  input  logic             probe_rsp_sent,
  output logic             wptr_stall,
  output logic             merge_close,
  output logic             proc_stall,
  output logic             bar_cmd,
  output logic             probe_mark,
  output logic             bar_retire
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  typedef enum logic [2:0] {
    S_IDLE, S_SEND, S_WACK, S_WEVT, S_MARK, S_WRSP, S_DONE
  } st_t;

  st_t              st, st_nx;
  logic             sys_mode;
  logic [CNT_W-1:0] cnt_q;

  wire accept  = bar_valid && bar_retired && older_writable;
  wire evt_hit = (cnt_q == ONE) && (evt_cnt == ZERO);
  wire active  = (st != S_IDLE) && (st != S_DONE);

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE: if (accept) st_nx = cfg_sys_barrier ? S_SEND : S_WEVT;
      S_SEND: st_nx = cmd_ack ? S_MARK : S_WACK;
      S_WACK: if (cmd_ack) st_nx = S_MARK;
      S_WEVT: if (evt_hit) st_nx = S_MARK;
      S_MARK: st_nx = S_WRSP;
      S_WRSP: if (probe_rsp_sent) st_nx = S_DONE;
      S_DONE: st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sys_mode <= 1'b0;
      cnt_q    <= '0;
    end else begin
      st    <= st_nx;
      cnt_q <= evt_cnt;
      if (st == S_IDLE && accept) sys_mode <= cfg_sys_barrier;
    end
  end

  assign wptr_stall  = active;
  assign merge_close = active;
  assign proc_stall  = active && !sys_mode;
  assign bar_cmd     = (st == S_SEND);
  assign probe_mark  = (st == S_MARK);
  assign bar_retire  = (st == S_DONE);
endmodule

module wbar_sq_handler_chk (
  input logic clk,
  input logic rst_n,
  input logic bar_valid,
  input logic bar_retired,
  input logic older_writable,
  input logic probe_rsp_sent,
  input logic wptr_stall,
  input logic merge_close,
  input logic proc_stall,
  input logic bar_cmd,
  input logic probe_mark,
  input logic bar_retire
);
  p_accept_needs_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wptr_stall) |-> $past(bar_valid && bar_retired && older_writable));
  p_merge_with_ptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(merge_close) |-> $rose(wptr_stall));
  p_proc_inside_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    proc_stall |-> wptr_stall);
  p_mark_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    probe_mark |=> !probe_mark);
  p_mark_stalled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    probe_mark |-> wptr_stall);
  p_cmd_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bar_cmd |-> $rose(wptr_stall) && !proc_stall);
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bar_retire |-> $past(probe_rsp_sent) && $fell(wptr_stall) && !merge_close && !proc_stall);
  p_one_hot_pulses_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bar_cmd, probe_mark, bar_retire}));
endmodule

bind wbar_sq_handler wbar_sq_handler_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bar_valid(bar_valid), .bar_retired(bar_retired),
  .older_writable(older_writable), .probe_rsp_sent(probe_rsp_sent),
  .wptr_stall(wptr_stall), .merge_close(merge_close), .proc_stall(proc_stall),
  .bar_cmd(bar_cmd), .probe_mark(probe_mark), .bar_retire(bar_retire));

// File: tb/wbar_sq_handler_test.sv
module wbar_sq_handler_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_sys_barrier = 1'b0, bar_valid = 1'b0, bar_retired = 1'b0, older_writable = 1'b0;
  logic [3:0] evt_cnt = 4'd0;
  logic cmd_ack = 1'b0, probe_rsp_sent = 1'b0;
  logic wptr_stall, merge_close, proc_stall, bar_cmd, probe_mark, bar_retire;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wbar_sq_handler #(.CNT_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_sys_barrier(cfg_sys_barrier),
    .bar_valid(bar_valid), .bar_retired(bar_retired), .older_writable(older_writable),
    .evt_cnt(evt_cnt), .cmd_ack(cmd_ack), .probe_rsp_sent(probe_rsp_sent),
    .wptr_stall(wptr_stall), .merge_close(merge_close), .proc_stall(proc_stall),
    .bar_cmd(bar_cmd), .probe_mark(probe_mark), .bar_retire(bar_retire));

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // expected {wptr_stall, merge_close, proc_stall, bar_cmd, probe_mark, bar_retire}
  task automatic expect_out(string req, logic [5:0] exp);
    logic [5:0] act;
    act = {wptr_stall, merge_close, proc_stall, bar_cmd, probe_mark, bar_retire};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: outputs %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_bar(logic v);
    bar_valid = v; bar_retired = v; older_writable = v;
  endtask

  task automatic finish_barrier(string req);
    probe_rsp_sent = 1'b1; set_bar(1'b0);
    step(); expect_out(req, 6'b000001);
    probe_rsp_sent = 1'b0;
    step(); expect_out(req, 6'b000000);
  endtask

  task automatic t_reset;
    step(); expect_out("R1", 6'b000000);
    rst_n = 1'b1;
    step(); expect_out("R1", 6'b000000);
  endtask

  task automatic t_partial;
    bar_valid = 1; bar_retired = 1; older_writable = 0; step(); expect_out("R2", 6'b000000);
    bar_valid = 1; bar_retired = 0; older_writable = 1; step(); expect_out("R2", 6'b000000);
    bar_valid = 0; bar_retired = 1; older_writable = 1; step(); expect_out("R2", 6'b000000);
    set_bar(0); step();
  endtask

  task automatic t_clear_mode;
    cfg_sys_barrier = 0; evt_cnt = 4'd3; set_bar(1);
    step(); expect_out("R3 R4", 6'b111000);
    evt_cnt = 4'd0; step(); expect_out("R5 3to0", 6'b111000);
    evt_cnt = 4'd2; cmd_ack = 1; step(); expect_out("R5 ack ignored", 6'b111000);
    cmd_ack = 0; probe_rsp_sent = 1; evt_cnt = 4'd1;
    step(); expect_out("R7 early rsp", 6'b111000);
    probe_rsp_sent = 0; evt_cnt = 4'd0;
    step(); expect_out("R5 mark", 6'b111010);
    step(); expect_out("R5 pulse", 6'b111000);
    finish_barrier("R7 clear");
  endtask

  task automatic t_set_mode;
    cfg_sys_barrier = 1; evt_cnt = 4'd1; set_bar(1);
    step(); expect_out("R6 cmd", 6'b110100);
    evt_cnt = 4'd0; step(); expect_out("R6 counter ignored", 6'b110000);
    cmd_ack = 1; step(); expect_out("R6 mark", 6'b110010);
    cmd_ack = 0; step(); expect_out("R6 pulse", 6'b110000);
    finish_barrier("R7 set");
  endtask

  task automatic t_mode_latch;
    cfg_sys_barrier = 0; evt_cnt = 4'd0; set_bar(1);
    step(); expect_out("R8 start", 6'b111000);
    cfg_sys_barrier = 1; cmd_ack = 1; set_bar(0);
    step(); expect_out("R8 latched", 6'b111000);
    cmd_ack = 0; evt_cnt = 4'd1; step();
    evt_cnt = 4'd0; step(); expect_out("R8 mark", 6'b111010);
    step();
    finish_barrier("R8 end");
  endtask

  task automatic t_back_to_back;
    cfg_sys_barrier = 1; set_bar(1);
    step(); expect_out("R9 first", 6'b110100);
    step(); expect_out("R9 no retrigger", 6'b110000);
    cmd_ack = 1; step(); cmd_ack = 0; step();
    probe_rsp_sent = 1; step(); expect_out("R9 retire", 6'b000001);
    probe_rsp_sent = 0; cfg_sys_barrier = 0;
    step(); expect_out("R9 accept idle", 6'b000000);
    step(); expect_out("R9 second", 6'b111000);
    set_bar(0); evt_cnt = 4'd1; step(); evt_cnt = 4'd0; step(); step();
    finish_barrier("R9 second end");
  endtask

  initial begin
    t_reset();
    t_partial();
    t_clear_mode();
    t_set_mode();
    t_mode_latch();
    t_back_to_back();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule